// File: doc/BRIEF.md
# Fifteen-Level Prioritised Interrupt Controller

This block gathers interrupt requests from fifteen sources, numbered 1 to 15, and presents the processor with a single 4-bit request level. That level is always the highest-numbered source that is both active and not masked. Level 0 is the "no request" code, and no source sits on it. A one-cycle pulse on a source input latches that source as pending. The processor's acknowledge, which carries a level, retires that source. Software can also retire pending sources through a write-one-to-clear register.

For testing, a force register lets individual levels be raised without any source pulse. It can be written only while the test-mode input is high, and it feeds the request logic only in that state. An acknowledge in test mode retires a forced level before it touches the pending level. Writes that set bits outside a register's legal field raise a one-cycle error pulse. Level 15 has no mask bit, so it cannot be masked.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A high `src_i[n]` for n in 1..15, sampled at a clock edge, sets pending bit n from that edge onward. `src_i[0]` has no effect.
- R2: While reset is asserted, and immediately after it, pending reads 0, force reads 0 and mask reads 0x0000_7FFE. `irq_level_o` is 0 and `reg_err_o` is 0.
- R3: A level n is active when bit n is set in (pending OR force-if-test-mode) and clear in mask. `irq_level_o` is the highest active level, searching from 15 down to 1, and is 0 when no level is active. The output follows register state with no added register stage.
- R4: A write to the mask register (address 1) stores only bits [14:1] of the data. Mask bit n blocks level n, and level 15 can never be masked.
- R5: A write to the clear register (address 2) removes every pending bit in [15:1] whose data bit is 1. Other pending bits are unchanged.
- R6: A write to the force register (address 3) stores bits [15:1] only while `test_mode_i` is 1. While `test_mode_i` is 0, such a write leaves the force register unchanged and the force bits do not affect `irq_level_o`.
- R7: With `ack_valid_i` high and `ack_level_i` = n (1..15), if `test_mode_i` is 1 and force bit n is set, then force bit n clears and pending is untouched. Otherwise pending bit n clears. An acknowledge of level 0 has no effect.
- R8: If a source pulse on level n falls in the same cycle as a clear of pending bit n, whether by clear-register write or by acknowledge, the pulse wins and bit n stays pending.
- R9: `reg_rdata_o` combinationally returns pending at address 0, mask at address 1, 0 at address 2 and force at address 3, with bit n standing for level n.
- R10: `reg_err_o` is high for exactly the cycle after a write that sets an illegal bit. For mask, bit 0 or any bit from 15 up is illegal. For clear and force, bit 0 or any bit from 16 up is illegal. Legal writes and writes to address 0 never raise it, and writes to address 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | Enables force register writes and the force term |
| src_i | input | 16 | Source pulses, bit n = level n, bit 0 unused |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| reg_err_o | output | 1 | One-cycle pulse after an illegal write |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Highest active level, 0 if none |

## Verification
Both the set path and the clear path can hit the same pending bit in one cycle. A source pulse can coincide with a clear-register write, or with an acknowledge of the same level. The bench drives the source and the clear in the same cycle for both cases. It then reads the pending register back and expects the bit still set, and it confirms that a later lone acknowledge removes it. A force write can also land in the same cycle as a test-mode acknowledge. The force path is judged by reading the force and pending registers after each acknowledge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned IRQ_LEVELS = 15;
  localparam int unsigned REG_DW     = 32;

  typedef enum logic [1:0] {
    ADDR_PEND  = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_CLR   = 2'd2,
    ADDR_FORCE = 2'd3
  } irq_addr_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LVL = 15,
  localparam int unsigned LW     = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_LVL:1] act_i,
  output logic [LW-1:0]    lvl_o
);

  // ascending scan: the last hit is the highest level
  always_comb begin
    lvl_o = '0;
    for (int i = 1; i <= int'(NUM_LVL); i++) begin
      if (act_i[i]) lvl_o = LW'(i);
    end
  end

endmodule

// File: rtl/irq_ack_route.sv
module irq_ack_route #(
  parameter int unsigned NUM_LVL = 15,
  localparam int unsigned LW     = $clog2(NUM_LVL + 1),
  localparam int unsigned VW     = NUM_LVL + 1
) (
  input  logic              ack_valid_i,
  input  logic [LW-1:0]     ack_level_i,
  input  logic              test_mode_i,
  input  logic [NUM_LVL:1]  force_i,
  output logic [VW-1:0]     pend_clr_o,
  output logic [VW-1:0]     force_clr_o
);

  assign pend_clr_o[0]  = 1'b0;
  assign force_clr_o[0] = 1'b0;

  for (genvar g = 1; g <= NUM_LVL; g++) begin : g_lvl
    logic hit;
    logic take_force;
    assign hit            = ack_valid_i && (ack_level_i == LW'(g));
    assign take_force     = test_mode_i && force_i[g];
    assign force_clr_o[g] = hit && take_force;
    assign pend_clr_o[g]  = hit && !take_force;
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LVL = IRQ_LEVELS,
  parameter int unsigned DW      = REG_DW,
  localparam int unsigned VW     = NUM_LVL + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [VW-1:0] src_set_i,
  input  logic [VW-1:0] ack_pend_clr_i,
  input  logic [VW-1:0] ack_force_clr_i,
  output logic [VW-1:0] pend_q,
  output logic [VW-1:0] mask_q,
  output logic [VW-1:0] force_q,
  output logic [DW-1:0] rdata_o,
  output logic          err_q
);

  localparam logic [VW-1:0] LVL_BITS  = {{NUM_LVL{1'b1}}, 1'b0};
  localparam logic [VW-1:0] MASK_BITS = LVL_BITS & ~(VW'(1) << NUM_LVL);
  localparam logic [DW-1:0] LVL_W     = DW'(LVL_BITS);
  localparam logic [DW-1:0] MASK_W    = DW'(MASK_BITS);

  logic          wr_mask, wr_clr, wr_force_any, wr_force;
  logic [VW-1:0] w1c_vec;
  logic [VW-1:0] pend_d, mask_d, force_d;
  logic          pend_en, mask_en, force_en;
  logic          err_d;

  // write decode
  always_comb begin
    wr_mask      = wr_en_i && (wr_addr_i == ADDR_MASK);
    wr_clr       = wr_en_i && (wr_addr_i == ADDR_CLR);
    wr_force_any = wr_en_i && (wr_addr_i == ADDR_FORCE);
    wr_force     = wr_force_any && test_mode_i;
    w1c_vec      = wr_clr ? wr_data_i[VW-1:0] : '0;
  end

  // next state; a set in the same cycle overrides any clear
  always_comb begin
    pend_d   = ((pend_q & ~w1c_vec & ~ack_pend_clr_i) | src_set_i) & LVL_BITS;
    pend_en  = (|src_set_i) || wr_clr || (|ack_pend_clr_i);

    mask_d   = wr_data_i[VW-1:0] & MASK_BITS;
    mask_en  = wr_mask;

    force_d  = wr_force ? (wr_data_i[VW-1:0] & LVL_BITS)
                        : (force_q & ~ack_force_clr_i);
    force_en = wr_force || (|ack_force_clr_i);

    err_d    = (wr_mask && (|(wr_data_i & ~MASK_W))) ||
               ((wr_clr || wr_force_any) && (|(wr_data_i & ~LVL_W)));
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= MASK_BITS;
      force_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (pend_en)  pend_q  <= pend_d;
      if (mask_en)  mask_q  <= mask_d;
      if (force_en) force_q <= force_d;
      err_q <= err_d;
    end
  end

  // read mux
  always_comb begin
    unique case (wr_addr_i)
      ADDR_PEND:  rdata_o = DW'(pend_q);
      ADDR_MASK:  rdata_o = DW'(mask_q);
      ADDR_FORCE: rdata_o = DW'(force_q);
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LVL = IRQ_LEVELS,
  parameter int unsigned DW      = REG_DW,
  localparam int unsigned LW     = $clog2(NUM_LVL + 1),
  localparam int unsigned VW     = NUM_LVL + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode_i,
  input  logic [VW-1:0] src_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          reg_err_o,
  input  logic          ack_valid_i,
  input  logic [LW-1:0] ack_level_i,
  output logic [LW-1:0] irq_level_o
);

  localparam logic [VW-1:0] LVL_BITS = {{NUM_LVL{1'b1}}, 1'b0};

  logic [VW-1:0] src_set;
  logic [VW-1:0] pend_vec, mask_vec, force_vec;
  logic [VW-1:0] ack_pend_clr, ack_force_clr;
  logic [VW-1:0] force_eff, act_vec;

  assign src_set = src_i & LVL_BITS;

  irq_ack_route #(.NUM_LVL(NUM_LVL)) u_ack (
    .ack_valid_i (ack_valid_i),
    .ack_level_i (ack_level_i),
    .test_mode_i (test_mode_i),
    .force_i     (force_vec[VW-1:1]),
    .pend_clr_o  (ack_pend_clr),
    .force_clr_o (ack_force_clr)
  );

  irq_regfile #(.NUM_LVL(NUM_LVL), .DW(DW)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .test_mode_i     (test_mode_i),
    .wr_en_i         (reg_wr_i),
    .wr_addr_i       (reg_addr_i),
    .wr_data_i       (reg_wdata_i),
    .src_set_i       (src_set),
    .ack_pend_clr_i  (ack_pend_clr),
    .ack_force_clr_i (ack_force_clr),
    .pend_q          (pend_vec),
    .mask_q          (mask_vec),
    .force_q         (force_vec),
    .rdata_o         (reg_rdata_o),
    .err_q           (reg_err_o)
  );

  always_comb begin
    force_eff = test_mode_i ? force_vec : '0;
    act_vec   = (pend_vec | force_eff) & ~mask_vec & LVL_BITS;
  end

  irq_prio_enc #(.NUM_LVL(NUM_LVL)) u_enc (
    .act_i (act_vec[VW-1:1]),
    .lvl_o (irq_level_o)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LVL = IRQ_LEVELS,
  parameter int unsigned DW      = REG_DW,
  localparam int unsigned LW     = $clog2(NUM_LVL + 1),
  localparam int unsigned VW     = NUM_LVL + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode_i,
  input logic [NUM_LVL:1] src_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic             ack_valid_i,
  input logic [LW-1:0]    ack_level_i,
  input logic [LW-1:0]    irq_level_o,
  input logic             reg_err_o,
  input logic [NUM_LVL:1] pend_q,
  input logic [NUM_LVL:1] mask_q,
  input logic [NUM_LVL:1] force_q
);

  localparam logic [DW-1:0] MASK_LEGAL = DW'({{(NUM_LVL-1){1'b1}}, 1'b0});

  logic [NUM_LVL:1] act_c;
  assign act_c = (pend_q | (test_mode_i ? force_q : '0)) & ~mask_q;

  for (genvar k = 1; k <= NUM_LVL; k++) begin : g_lvl
    assert_src_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      src_i[k] |=> pend_q[k]);

    assert_lvl_is_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level_o == LW'(k)) |-> act_c[k]);

    assert_lvl_is_highest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_c[k] |-> (irq_level_o >= LW'(k)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && (ack_level_i == LW'(k)) && !test_mode_i && !src_i[k])
      |=> !pend_q[k]);
  end

  assert_force_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode_i |=> $stable(force_q));

  assert_mask_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && (reg_addr_i == ADDR_MASK) && ((reg_wdata_i & ~MASK_LEGAL) != '0))
    |=> reg_err_o);

  assert_pend_wr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && (reg_addr_i == ADDR_PEND)) |=> !reg_err_o);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LVL(NUM_LVL), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .test_mode_i (test_mode_i),
  .src_i       (src_i[VW-1:1]),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ack_valid_i (ack_valid_i),
  .ack_level_i (ack_level_i),
  .irq_level_o (irq_level_o),
  .reg_err_o   (reg_err_o),
  .pend_q      (pend_vec[VW-1:1]),
  .mask_q      (mask_vec[VW-1:1]),
  .force_q     (force_vec[VW-1:1])
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  import irq_prio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        test_mode;
  logic [15:0] src;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        ack_valid;
  logic [3:0]  ack_level;
  logic [3:0]  irq_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode_i (test_mode),
    .src_i       (src),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .reg_err_o   (reg_err),
    .ack_valid_i (ack_valid),
    .ack_level_i (ack_level),
    .irq_level_o (irq_level)
  );

  // {mask[15:0], source[15:0], expected level[3:0]}
  localparam logic [35:0] VECS [8] = '{
    36'h0000_0002_1,
    36'h0000_8002_F,
    36'h0000_0A50_B,
    36'h0800_0A50_9,
    36'h7FFE_0A50_0,
    36'h7FFE_8000_F,
    36'h0000_0001_0,
    36'h00F0_00F8_3
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] s);
    src = s;
    tick();
    src = '0;
  endtask

  task automatic ack(input logic [3:0] l);
    ack_valid = 1'b1; ack_level = l;
    tick();
    ack_valid = 1'b0; ack_level = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; test_mode = 1'b0; src = '0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; ack_valid = 1'b0; ack_level = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();

    // R2 reset state
    rd(ADDR_PEND, d);  chk("R2 pending", d, 32'h0);
    rd(ADDR_MASK, d);  chk("R2 mask", d, 32'h0000_7FFE);
    rd(ADDR_FORCE, d); chk("R2 force", d, 32'h0);
    chk("R2 level", 32'(irq_level), 32'h0);
    chk("R2 err", 32'(reg_err), 32'h0);

    // table: R3 priority, R4 mask and level 15, R1 bit 0 ignored
    for (int i = 0; i < 8; i++) begin
      wr(ADDR_MASK, 32'(VECS[i][35:20]));
      wr(ADDR_CLR, 32'h0000_FFFE);
      pulse(VECS[i][19:4]);
      chk($sformatf("R3 level vec%0d", i), 32'(irq_level), 32'(VECS[i][3:0]));
      rd(ADDR_PEND, d);
      chk($sformatf("R1 pending vec%0d", i), d, 32'(VECS[i][19:4] & 16'hFFFE));
    end
    // state now: mask 0x00F0, pending 0x00F8

    // R4 / R10 illegal mask write
    wr(ADDR_MASK, 32'h0000_8004);
    chk("R10 mask err pulse", 32'(reg_err), 32'h1);
    rd(ADDR_MASK, d); chk("R4 mask kept bits", d, 32'h0000_0004);
    tick();
    chk("R10 err one cycle", 32'(reg_err), 32'h0);

    // R10 write to pending address ignored
    wr(ADDR_PEND, 32'hFFFF_FFFF);
    chk("R10 pend wr no err", 32'(reg_err), 32'h0);
    rd(ADDR_PEND, d); chk("R10 pend wr ignored", d, 32'h0000_00F8);

    // R5 clear register
    wr(ADDR_CLR, 32'h0001_0008);
    chk("R5 clr err", 32'(reg_err), 32'h1);
    rd(ADDR_PEND, d); chk("R5 w1c partial", d, 32'h0000_00F0);
    wr(ADDR_CLR, 32'h0000_00F0);
    chk("R5 legal clr no err", 32'(reg_err), 32'h0);
    rd(ADDR_PEND, d); chk("R5 w1c all", d, 32'h0);

    // R6 force gating
    wr(ADDR_FORCE, 32'h0000_0020);
    rd(ADDR_FORCE, d); chk("R6 force locked", d, 32'h0);
    chk("R6 level no force", 32'(irq_level), 32'h0);
    test_mode = 1'b1;
    wr(ADDR_FORCE, 32'h0000_0021);
    chk("R10 force err", 32'(reg_err), 32'h1);
    rd(ADDR_FORCE, d); chk("R6 force stored", d, 32'h0000_0020);
    chk("R6 forced level", 32'(irq_level), 32'h5);
    test_mode = 1'b0;
    #1;
    chk("R6 force off in normal mode", 32'(irq_level), 32'h0);

    // R7 acknowledge routing
    test_mode = 1'b1;
    pulse(16'h0020);
    ack(4'd5);
    rd(ADDR_FORCE, d); chk("R7 ack clears force", d, 32'h0);
    rd(ADDR_PEND, d);  chk("R7 pending kept", d, 32'h0000_0020);
    chk("R7 level still 5", 32'(irq_level), 32'h5);
    ack(4'd5);
    rd(ADDR_PEND, d);  chk("R7 ack clears pending", d, 32'h0);
    chk("R7 level zero", 32'(irq_level), 32'h0);
    pulse(16'h0002);
    ack(4'd0);
    rd(ADDR_PEND, d);  chk("R7 ack level 0 no effect", d, 32'h0000_0002);
    chk("R7 level 1", 32'(irq_level), 32'h1);

    // R8 set beats clear
    test_mode = 1'b0;
    src = 16'h0002;
    wr(ADDR_CLR, 32'h0000_0002);
    src = '0;
    rd(ADDR_PEND, d); chk("R8 src beats w1c", d, 32'h0000_0002);
    src = 16'h0002;
    ack(4'd1);
    src = '0;
    rd(ADDR_PEND, d); chk("R8 src beats ack", d, 32'h0000_0002);
    ack(4'd1);
    rd(ADDR_PEND, d); chk("R7 lone ack clears", d, 32'h0);

    // R9 clear register reads zero
    rd(ADDR_CLR, d); chk("R9 clr reads 0", d, 32'h0);
    rd(ADDR_MASK, d); chk("R9 mask readback", d, 32'h0000_0004);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule